// File: doc/BRIEF.md
# Mode-Encoded Period Timer

A free-running counter that steps once per enabled clock and is compared with a period value on every cycle. When the count equals the period, the counter returns to zero on the following clock and goes on counting. In that cycle a one-clock match pulse is raised, so a downstream block sees one strobe per period.

A five-bit mode code sets how a software enable (`on_i`) and an external control line (`ext_i`) act on the count. The external line can gate counting with either polarity. It can clear the counter on a rising edge, a falling edge or either edge. It can hold the counter at zero while it sits at a chosen level. Edges are found by comparing `ext_i` with its value at the previous clock, and `ext_i` is taken to be synchronous to `clk`.

Top module: `ptmr_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `count_o` = 0 and `match_o` = 0.
- R2: On an enabled cycle, the count rises by one if it differs from `period_i`. If it equals `period_i`, the count becomes 0 on the next clock.
- R3: `match_o` is high for exactly the one cycle after an enabled clock at which the count equalled `period_i`. It is low after any cycle in which the counter was halted or forced to zero.
- R4: Mode 0 (software gate): the counter runs while `on_i` = 1 and keeps its value while `on_i` = 0.
- R5: Mode 1 counts only when `on_i` = 1 and `ext_i` = 1. Mode 2 counts only when `on_i` = 1 and `ext_i` = 0. Otherwise the count holds.
- R6: Modes 3, 4 and 5 count while `on_i` = 1. An edge is a cycle whose `ext_i` differs from its value one clock earlier, and that value is 0 after reset. Mode 3 clears on any edge, mode 4 on a rising edge (0 to 1) and mode 5 on a falling edge (1 to 0). The clear shows on the next clock whatever the value of `on_i`. It wins over a period match, and no pulse is given in that case.
- R7: Mode 6 forces the count to 0 while `ext_i` = 0, and mode 7 forces it to 0 while `ext_i` = 1. At the other level the counter runs while `on_i` = 1 and holds while `on_i` = 0.
- R8: Mode codes 8 to 31 force the count to 0 and keep `match_o` low.
- R9: With `period_i` = 0 and counting enabled, the count stays 0 and `match_o` is high on every enabled cycle after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| on_i | input | 1 | Software enable |
| ext_i | input | 1 | External gate / reset line |
| mode_i | input | 5 | Mode code, 0 to 7 valid |
| period_i | input | CNT_W (8) | Period compare value |
| count_o | output | CNT_W (8) | Current count (registered) |
| match_o | output | 1 | One-clock period-match pulse (registered) |

## Verification
Each result appears one clock after the inputs that cause it: a step, a wrap to zero, a clear or a hold all show at the edge after the sampled inputs, and the match pulse shows in that same cycle. Edge clears take one more register into account, because the edge is found against the value of `ext_i` at the clock before. The bench drives inputs on falling edges and updates its own model on each rising edge from the inputs it sees there. It compares count and pulse at the next falling edge, so each expected value is checked in exactly the cycle the design's registers present it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    M_SOFT      = 5'd0,
    M_GATE_HI   = 5'd1,
    M_GATE_LO   = 5'd2,
    M_EDGE_ANY  = 5'd3,
    M_EDGE_RISE = 5'd4,
    M_EDGE_FALL = 5'd5,
    M_HOLD_LO   = 5'd6,
    M_HOLD_HI   = 5'd7
  } ptmr_mode_e;

  typedef struct packed {
    logic run;   // advance the counter this cycle
    logic zero;  // force the counter to zero (wins over run)
  } ptmr_ctl_t;
endpackage

// File: rtl/ptmr_edge.sv
module ptmr_edge (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic ext_q;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_i;
  end

  assign rise_o = ext_i & ~ext_q;
  assign fall_o = ~ext_i & ext_q;
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic              on_i,
  input  logic              ext_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [MODE_W-1:0] mode_i,
  output ptmr_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (mode_i)
      M_SOFT: begin
        ctl_o.run = on_i;
      end
      M_GATE_HI: begin
        ctl_o.run = on_i & ext_i;
      end
      M_GATE_LO: begin
        ctl_o.run = on_i & ~ext_i;
      end
      M_EDGE_ANY: begin
        ctl_o.run  = on_i;
        ctl_o.zero = rise_i | fall_i;
      end
      M_EDGE_RISE: begin
        ctl_o.run  = on_i;
        ctl_o.zero = rise_i;
      end
      M_EDGE_FALL: begin
        ctl_o.run  = on_i;
        ctl_o.zero = fall_i;
      end
      M_HOLD_LO: begin
        ctl_o.run  = on_i;
        ctl_o.zero = ~ext_i;
      end
      M_HOLD_HI: begin
        ctl_o.run  = on_i;
        ctl_o.zero = ext_i;
      end
      default: begin
        ctl_o.zero = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ptmr_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             mat_q;
  logic             hit;

  assign hit = (cnt_q == period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mat_q <= 1'b0;
    end else if (ctl_i.zero) begin
      cnt_q <= '0;
      mat_q <= 1'b0;
    end else if (ctl_i.run) begin
      if (hit) begin
        cnt_q <= '0;
        mat_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
        mat_q <= 1'b0;
      end
    end else begin
      mat_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign match_o = mat_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_i,
  input  logic             ext_i,
  input  logic [4:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic      rise_w;
  logic      fall_w;
  ptmr_ctl_t ctl_w;

  ptmr_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .ext_i  (ext_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  ptmr_ctrl u_ctrl (
    .on_i   (on_i),
    .ext_i  (ext_i),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .mode_i (mode_i),
    .ctl_o  (ctl_w)
  );

  ptmr_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .ctl_i    (ctl_w),
    .period_i (period_i),
    .count_o  (count_o),
    .match_o  (match_o)
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             on_i,
  input logic             ext_i,
  input logic [4:0]       mode_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] count_o,
  input logic             match_o,
  input logic             rise_w
);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd0 && on_i && count_o == period_i) |=> (count_o == '0 && match_o));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd0 && on_i && count_o != period_i) |=>
      (count_o == CNT_W'($past(count_o) + 1'b1) && !match_o));

  p_match_zero_r3: assert property (@(posedge clk) disable iff (rst)
    match_o |-> count_o == '0);

  p_sw_halt_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd0 && !on_i) |=> ($stable(count_o) && !match_o));

  p_gate_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd1 && !ext_i) |=> ($stable(count_o) && !match_o));

  p_rise_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd4 && rise_w) |=> (count_o == '0 && !match_o));

  p_hold_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 5'd7 && ext_i) |=> (count_o == '0 && !match_o));

  p_bad_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i > 5'd7) |=> (count_o == '0 && !match_o));
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .on_i     (on_i),
  .ext_i    (ext_i),
  .mode_i   (mode_i),
  .period_i (period_i),
  .count_o  (count_o),
  .match_o  (match_o),
  .rise_w   (rise_w)
);

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         on_i = 1'b0;
  logic         ext_i = 1'b0;
  logic [4:0]   mode_i = 5'd0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] count_o;
  logic         match_o;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int m_cnt, m_mat, m_prev;
  int r_e, f_e, zero, go, md;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptmr_top #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .on_i(on_i), .ext_i(ext_i),
    .mode_i(mode_i), .period_i(period_i),
    .count_o(count_o), .match_o(match_o)
  );

  // behavioural reference model, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_mat = 0; m_prev = 0;
    end else begin
      md  = int'(mode_i);
      r_e = (ext_i && m_prev == 0) ? 1 : 0;
      f_e = (!ext_i && m_prev == 1) ? 1 : 0;
      zero = (md > 7) ||
             (md == 3 && (r_e || f_e)) || (md == 4 && r_e) || (md == 5 && f_e) ||
             (md == 6 && !ext_i) || (md == 7 && ext_i);
      go = on_i && ((md == 1) ? ext_i : (md == 2) ? !ext_i : 1'b1);
      if (zero) begin
        m_cnt = 0; m_mat = 0;
      end else if (go) begin
        if (m_cnt == int'(period_i)) begin m_cnt = 0; m_mat = 1; end
        else begin m_cnt = (m_cnt + 1) % 256; m_mat = 0; end
      end else begin
        m_mat = 0;
      end
      m_prev = ext_i ? 1 : 0;
    end
  end

  task automatic compare();
    checks++;
    if (int'(count_o) != m_cnt || int'(match_o) != m_mat) begin
      errors++;
      $display("FAIL %s: count=%0d match=%0d expected count=%0d match=%0d",
               cur_req, count_o, match_o, m_cnt, m_mat);
    end
  endtask

  // one cycle: check at falling edge, then apply next inputs
  task automatic cyc(input bit on, input bit ext, input int mode, input int per);
    @(negedge clk);
    compare();
    on_i = on; ext_i = ext; mode_i = 5'(mode); period_i = W'(per);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (count_o != '0 || match_o != 1'b0) begin
      errors++;
      $display("FAIL R1: count=%0d match=%0d expected count=0 match=0", count_o, match_o);
    end
    rst = 1'b0;

    cur_req = "R2";
    for (int i = 0; i < 16; i++) cyc(1, 0, 0, 5);
    cur_req = "R3";
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 2);
    cur_req = "R4";
    for (int i = 0; i < 12; i++) cyc(i % 4 != 0, 0, 0, 6);

    cur_req = "R5";
    for (int i = 0; i < 20; i++) cyc(i % 7 != 3, (i % 5) < 3, 1, 4);
    for (int i = 0; i < 20; i++) cyc(i % 6 != 2, (i % 5) < 2, 2, 4);

    cur_req = "R6";
    for (int i = 0; i < 24; i++) cyc(1, (i / 5) % 2 == 1, 3, 4);
    for (int i = 0; i < 24; i++) cyc(i % 9 != 8, (i / 4) % 2 == 1, 4, 3);
    for (int i = 0; i < 24; i++) cyc(i % 5 != 1, (i / 6) % 2 == 1, 5, 4);

    cur_req = "R7";
    for (int i = 0; i < 20; i++) cyc(i % 7 != 5, (i / 6) % 2 == 0, 6, 3);
    for (int i = 0; i < 20; i++) cyc(i % 8 != 4, (i / 5) % 2 == 1, 7, 5);

    cur_req = "R8";
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 9);
    for (int i = 0; i < 12; i++) cyc(1, i % 2 == 1, 8 + i * 2, 2);

    cur_req = "R9";
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);

    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (count_o != '0 || match_o != 1'b0) begin
      errors++;
      $display("FAIL R1: count=%0d match=%0d expected count=0 match=0", count_o, match_o);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: count=%0d match=%0d expected run to finish", count_o, match_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule